// File: doc/BRIEF.md
# Display Byte Packer with Endian and RGB Stages

This block collects bytes from an 8-bit display data bus and builds 32-bit words from them. The number of bytes that make up one word is set by a control input. Each byte is shifted right by a programmable amount as it arrives. When the word is complete it can be reordered to big-endian. An optional last stage then expands it into an RGB word. The stages always run in that order: shift, then byte order, then RGB.

The control inputs are the byte count per word, the shift amount, the byte-order select, an RGB enable and a word-length code. The byte-order select, the RGB enable and the word-length code are sampled on the cycle that carries the last byte of a word. The shift amount is applied to each byte on its own arrival cycle. The output is a registered 32-bit word with a one-cycle valid strobe.

Top module: `byte_word_packer`

## Requirements
- R1: While reset is asserted and after reset is released, `out_valid` is 0 and `out_word` is 0 until the first word completes.
- R2: With `big_endian` = 0, the first byte received lands in bits [7:0], the second in [15:8], and so on; the bytes 0x11, 0x22, 0x33 with a count of 3 give 0x00332211.
- R3: With `big_endian` = 1, the order of the received bytes is reversed within the word; the bytes 0x11, 0x22, 0x33 with a count of 3 give 0x00112233.
- R4: A word is emitted once the programmed number of bytes has been received. `subwords` values 1 to 4 select that count, and 0 or 5 to 7 select 4. `out_valid` is high for exactly the cycle after the last byte's clock edge, and the byte count then restarts from zero. Reset also restarts a partly filled word.
- R5: Bytes above the programmed count are zero in the output word.
- R6: Each byte is logically shifted right by `shift_amt` (0 to 7) bits on arrival, before the byte-order stage.
- R7: A cycle with `in_valid` low consumes no byte and leaves the word being built unchanged.
- R8: With `rgb_en` = 1 and `word_len` = 2'b01 (16-bit 5-6-5), bits [15:0] of the arranged word are split as R = [15:11], G = [10:5] and B = [4:0]. Each component is widened to 8 bits by appending its top bits (R and B: top 3 bits, G: top 2 bits), and the output is 0x00RRGGBB.
- R9: With `word_len` = 2'b00 (8-bit), `rgb_en` has no effect and the arranged word is output unchanged.
- R10: With `rgb_en` = 1 and `word_len` = 2'b10 or 2'b11 (24-bit), the output keeps bits [23:0] of the arranged word and clears bits [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | In this cycle, in_byte carries a byte |
| in_byte | input | 8 | Incoming data byte |
| subwords | input | 3 | Bytes per word (1-4; 0 and 5-7 mean 4) |
| shift_amt | input | 3 | Right shift applied to each byte |
| big_endian | input | 1 | Reverse byte order in the completed word |
| rgb_en | input | 1 | Enable the RGB expansion stage |
| word_len | input | 2 | 00 8-bit, 01 16-bit 5-6-5, 1x 24-bit |
| out_valid | output | 1 | One-cycle strobe for a completed word |
| out_word | output | 32 | Completed word |

## Verification
The packing is tried with one to four bytes in both byte orders. Distinct byte values show whether each byte lands in the right lane, and whether the lanes above the count stay zero. Non-zero shifts combined with big-endian order show that the shift runs before the reordering. Single-colour 5-6-5 words and a mid-grey word separate the placement of each component from the bit replication, and the same bytes are also sent under the 8-bit and 24-bit codes to show that the enable is ignored or only truncates there. Idle gaps filled with 0xFF, back-to-back single-byte words, a count code of zero and a reset in the middle of a word check the counting.

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [BYTE_W-1:0]         in_byte,
  input  logic [$clog2(LANES):0]    subwords,
  input  logic [$clog2(BYTE_W)-1:0] shift_amt,
  input  logic                      big_endian,
  input  logic                      rgb_en,
  input  logic [1:0]                word_len,
  output logic                      out_valid,
  output logic [BYTE_W*LANES-1:0]   out_word
);
  localparam int WORD_W = BYTE_W * LANES;
  localparam int CNT_W  = $clog2(LANES) + 1;

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc, le_word, be_word, arranged, next_word;
  logic [CNT_W-1:0]  n_eff;
  logic [BYTE_W-1:0] shifted;
  logic              last, conv_active;
  logic [7:0]        r8, g8, b8;

  assign n_eff = (subwords == '0 || int'(subwords) > LANES) ? CNT_W'(LANES) : subwords;
  assign shifted = in_byte >> shift_amt;
  assign last = in_valid && ((cnt + 1'b1) == n_eff);

  always_comb begin
    le_word = acc;
    for (int i = 0; i < LANES; i++)
      if (int'(cnt) == i) le_word[i*BYTE_W +: BYTE_W] = shifted;
  end

  always_comb begin
    be_word = '0;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES; j++)
        if (i < int'(n_eff) && j == int'(n_eff) - 1 - i)
          be_word[i*BYTE_W +: BYTE_W] = le_word[j*BYTE_W +: BYTE_W];
  end

  assign arranged    = big_endian ? be_word : le_word;
  assign conv_active = rgb_en && (word_len != 2'b00);

  assign r8 = {arranged[15:11], arranged[15:13]};
  assign g8 = {arranged[10:5],  arranged[10:9]};
  assign b8 = {arranged[4:0],   arranged[4:2]};

  always_comb begin
    if (!conv_active)
      next_word = arranged;
    else if (word_len == 2'b01)
      next_word = WORD_W'({r8, g8, b8});
    else
      next_word = WORD_W'(arranged[23:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= last;
      if (last) begin
        cnt      <= '0;
        acc      <= '0;
        out_word <= next_word;
      end else if (in_valid) begin
        cnt <= cnt + 1'b1;
        acc <= le_word;
      end
    end
  end

  assert_valid_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt) && !out_valid));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && n_eff == 1 && !conv_active) |=> (out_word[WORD_W-1:BYTE_W] == '0));

  assert_rgb_top_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && conv_active) |=> (out_word[WORD_W-1:24] == '0));
endmodule

// File: tb/test_byte_word_packer.sv
module test_byte_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [2:0]  subwords = 3'd1;
  logic [2:0]  shift_amt = 3'd0;
  logic        big_endian = 1'b0;
  logic        rgb_en = 1'b0;
  logic [1:0]  word_len = 2'b00;
  logic        out_valid;
  logic [31:0] out_word;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  byte_word_packer i_byte_word_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .subwords(subwords), .shift_amt(shift_amt), .big_endian(big_endian),
    .rgb_en(rgb_en), .word_len(word_len), .out_valid(out_valid), .out_word(out_word));

  // {count, shift, big_endian, rgb_en, word_len, bytes b0..b3, expected}
  localparam int NV = 15;
  localparam logic [73:0] VEC [NV] = '{
    {3'd3, 3'd0, 1'b0, 1'b0, 2'b00, 32'h11223300, 32'h00332211},
    {3'd3, 3'd0, 1'b1, 1'b0, 2'b00, 32'h11223300, 32'h00112233},
    {3'd4, 3'd0, 1'b0, 1'b0, 2'b00, 32'h01020304, 32'h04030201},
    {3'd4, 3'd0, 1'b1, 1'b0, 2'b00, 32'h01020304, 32'h01020304},
    {3'd1, 3'd0, 1'b0, 1'b0, 2'b00, 32'hAB000000, 32'h000000AB},
    {3'd2, 3'd4, 1'b0, 1'b0, 2'b00, 32'hF00F0000, 32'h0000000F},
    {3'd2, 3'd4, 1'b1, 1'b0, 2'b00, 32'hF00F0000, 32'h00000F00},
    {3'd3, 3'd1, 1'b1, 1'b0, 2'b00, 32'h22446600, 32'h00112233},
    {3'd2, 3'd0, 1'b0, 1'b1, 2'b01, 32'h00F80000, 32'h00FF0000},
    {3'd2, 3'd0, 1'b0, 1'b1, 2'b01, 32'h1F000000, 32'h000000FF},
    {3'd2, 3'd0, 1'b1, 1'b1, 2'b01, 32'h07E00000, 32'h0000FF00},
    {3'd2, 3'd0, 1'b0, 1'b1, 2'b01, 32'h10840000, 32'h00848284},
    {3'd4, 3'd0, 1'b0, 1'b1, 2'b00, 32'h01020304, 32'h04030201},
    {3'd4, 3'd0, 1'b0, 1'b1, 2'b10, 32'h01020304, 32'h00030201},
    {3'd0, 3'd0, 1'b0, 1'b0, 2'b00, 32'hAABBCCDD, 32'hDDCCBBAA}
  };

  function automatic string tag_of(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R2 R5";
      3: return "R3";
      4: return "R5";
      5, 6: return "R6";
      7: return "R6 R3";
      8, 9, 10, 11: return "R8";
      12: return "R9";
      13: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic run_word(input logic [2:0] n, input logic [2:0] sh, input logic be,
                          input logic rgb, input logic [1:0] wl, input logic [31:0] bytes,
                          input bit gap, input string tag, input logic [31:0] exp);
    int cnt = (n == 0 || n > 4) ? 4 : int'(n);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      if (i > 0) chk(out_valid == 1'b0, "R4 early valid", 32'(out_valid), 32'd0);
      in_valid = 1'b1; in_byte = bytes[31-8*i -: 8];
      subwords = n; shift_amt = sh; big_endian = be; rgb_en = rgb; word_len = wl;
      if (gap && i + 1 < cnt) begin
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'hFF;   // R7 idle cycle
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00;
    chk(out_valid == 1'b1, {tag, " valid"}, 32'(out_valid), 32'd1);
    chk(out_word == exp, tag, out_word, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 single pulse", 32'(out_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_word == 32'h0, "R1 in reset", out_word, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_word == 32'h0, "R1 after reset", out_word, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [73:0] v = VEC[k];
      run_word(v[73:71], v[70:68], v[67], v[66], v[65:64], v[63:32], (k % 2) == 1,
               tag_of(k), v[31:0]);
    end

    // R7: idle cycles with garbage leave the partial word untouched
    run_word(3'd4, 3'd0, 1'b1, 1'b0, 2'b00, 32'h5A6B7C8D, 1'b1, "R7", 32'h5A6B7C8D);

    // R4: back-to-back single-byte words
    @(negedge clk);
    subwords = 3'd1; shift_amt = 3'd0; big_endian = 1'b0; rgb_en = 1'b0; word_len = 2'b00;
    in_valid = 1'b1; in_byte = 8'hAB;
    @(negedge clk);
    in_byte = 8'hCD;
    chk(out_valid == 1'b1 && out_word == 32'h000000AB, "R4 b2b first", out_word, 32'h000000AB);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_word == 32'h000000CD, "R4 b2b second", out_word, 32'h000000CD);
    @(negedge clk);

    // R4: reset in the middle of a word restarts the count
    subwords = 3'd4;
    in_valid = 1'b1; in_byte = 8'hEE;
    @(negedge clk); in_byte = 8'hDD;
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_word == 32'h0, "R1 reset clears", out_word, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    run_word(3'd4, 3'd0, 1'b0, 1'b0, 2'b00, 32'h01020304, 1'b0, "R4 after reset", 32'h04030201);

    // R9: the 8-bit code with rgb_en on passes the arranged word
    run_word(3'd2, 3'd0, 1'b1, 1'b1, 2'b00, 32'hF8000000, 1'b0, "R9", 32'h0000F800);
    // R10: the 24-bit code 2'b11 truncates
    run_word(3'd4, 3'd0, 1'b1, 1'b1, 2'b11, 32'h99887766, 1'b0, "R10", 32'h00887766);
    // R4: count code 6 means four bytes
    run_word(3'd6, 3'd0, 1'b0, 1'b0, 2'b00, 32'h10203040, 1'b0, "R4 code6", 32'h40302010);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule